// File: doc/BRIEF.md
# Register Rename Map Unit

This block sits at the rename stage of an out-of-order core and handles one decoded instruction per cycle. It turns the architectural register numbers named by the instruction into physical register numbers. The two source operands are looked up in a mapping table. A destination gets a physical register taken from a free pool, so every produced value has its own physical register. Downstream issue logic uses only physical numbers, which keeps dependency tracking unambiguous.

For each accepted instruction the unit writes a record into an in-order active list. The record holds the destination, the newly assigned physical register and the mapping it replaced. Graduation retires the oldest record and gives the displaced register back to the pool. An abort caused by an exception or a wrong branch guess names an active-list slot. The unit then unwinds the list from the youngest record down to that slot, one record per cycle. While the unwind runs, renaming is held off.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds physical registers NUM_LOG to NUM_PHYS-1 and hands them out in ascending order. `stall` is low.
- R2: `phy_src_a` and `phy_src_b` show, in the same cycle, the current mapping of `dec_src_a` and `dec_src_b`. That mapping includes every rename accepted at earlier clock edges. A source equal to the instruction's own destination sees the mapping from before that instruction.
- R3: An accepted instruction with `dec_has_dst`=1 and a non-zero `dec_dst` gets the oldest pool entry on `phy_dst`. It also gets the replaced mapping on `phy_dst_old`. The new mapping is visible from the next cycle on.
- R4: An instruction without a destination, or with destination 0, takes nothing from the pool and changes no mapping. Architectural register 0 always maps to physical register 0.
- R5: Each accepted instruction reports its active-list slot on `ren_tag`. Slots count up by one per accepted instruction and wrap from AL_DEPTH-1 to 0. `stall` is high whenever the active list holds AL_DEPTH records.
- R6: `grad_valid` retires the oldest record. If that record had a destination, its replaced register joins the tail of the pool and is handed out in FIFO order. `grad_valid` has no effect when the list is empty.
- R7: `stall` is high when the pool is empty and the instruction needs a destination. It stays low in that case for an instruction without one.
- R8: A rename and a graduation in the same cycle both take effect. The rename is served from the pool contents before the graduation's return, so a register freed in that cycle can only be handed out from the next cycle on.
- R9: `stall` is high in the cycle `abort_valid` is asserted. It stays high for exactly N further cycles, where N is the number of records from the youngest down to and including slot `abort_tag`. Graduation is not requested during an abort or an unwind.
- R10: After the unwind every mapping is as it was before the aborted instructions. Their new registers have joined the pool tail, youngest first. Their slots are handed out again starting at `abort_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_has_dst | input | 1 | Instruction writes a destination register |
| dec_dst | input | LW | Architectural destination |
| dec_src_a | input | LW | Architectural source A |
| dec_src_b | input | LW | Architectural source B |
| grad_valid | input | 1 | Retire the oldest active-list record |
| abort_valid | input | 1 | Start an unwind |
| abort_tag | input | TW | Slot of the oldest instruction to undo |
| stall | output | 1 | Instruction not accepted this cycle |
| phy_src_a | output | PW | Physical register for source A |
| phy_src_b | output | PW | Physical register for source B |
| phy_dst | output | PW | Newly assigned physical destination (0 when none) |
| phy_dst_old | output | PW | Mapping replaced by the destination |
| ren_tag | output | TW | Active-list slot of this instruction |

## Verification
A rename and a graduation can land in the same cycle. The two then compete for the pool, because one takes from its head and the other returns to its tail. The bench drives such pairs when the active list is full, when the pool has just run dry, and when both have room. A reference model in the bench serves the rename from the pool contents before the return, and it predicts `stall`, `phy_dst` and the later hand-out order. Unwinds are started at a middle slot and at the oldest slot. The number of stalled cycles and a sweep of every mapping afterwards are compared against the model.

// File: rtl/rmu_pkg.sv
// Shared types for the rename map unit.
package rmu_pkg;
    // Operating mode of the rename stage.
    typedef enum logic {
        RN_RUN  = 1'b0,
        RN_WALK = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rmu_map_table.sv
// Architectural-to-physical mapping table.
// Three combinational reads (two sources, one old destination), one write.
// Assumes the caller never writes entry 0.
module rmu_map_table #(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    input  logic [LW-1:0] rd_b_idx,
    input  logic [LW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a,
    output logic [PW-1:0] rd_b,
    output logic [PW-1:0] rd_d,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_val
);
    logic [PW-1:0] slot [NUM_LOG];

    // Identity mapping on reset, single write port afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_LOG; k++) slot[k] <= PW'(k);
        end else if (wr_en) begin
            slot[wr_idx] <= wr_val;
        end
    end

    // Combinational lookups.
    always_comb begin
        rd_a = slot[rd_a_idx];
        rd_b = slot[rd_b_idx];
        rd_d = slot[rd_d_idx];
    end

    AST_ZERO_PINNED: assert property (@(posedge clk) disable iff (!rst_n) slot[0] == '0); // R4
    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> wr_idx != '0); // R4
endmodule

// File: rtl/rmu_free_list.sv
// Circular FIFO of unmapped physical register numbers.
// Pops from the head, pushes at the tail. Starts full with NUM_LOG..NUM_PHYS-1.
// Assumes the caller never pops when empty.
module rmu_free_list #(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int DEPTH = NUM_PHYS - NUM_LOG,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    output logic [PW-1:0] head_val,
    output logic          empty
);
    logic [PW-1:0] ring [DEPTH];
    logic [IW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer, occupancy and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ring[k] <= PW'(NUM_LOG + k);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(DEPTH);
        end else begin
            if (push) begin
                ring[wr_ptr] <= push_val;
                wr_ptr       <= step_ptr(wr_ptr);
            end
            if (pop) rd_ptr <= step_ptr(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Head value and empty flag.
    always_comb begin
        head_val = ring[rd_ptr];
        empty    = (count == '0);
    end

    AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R7
    AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> count != CW'(DEPTH)); // R6
endmodule

// File: rtl/rmu_active_list.sv
// In-order ring of rename records {has_dst, ldst, pnew, pold}.
// Push at the tail, retire at the head, unwind from the tail.
// Assumes a tail pop never coincides with a push or a head pop.
module rmu_active_list #(
    parameter int DEPTH = 48,
    parameter int LW    = 5,
    parameter int PW    = 6,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int RW = 1 + LW + 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_has,
    input  logic [LW-1:0] push_ldst,
    input  logic [PW-1:0] push_pnew,
    input  logic [PW-1:0] push_pold,
    input  logic          pop_head,
    input  logic          pop_tail,
    output logic          head_has,
    output logic [PW-1:0] head_pold,
    output logic          tail_has,
    output logic [LW-1:0] tail_ldst,
    output logic [PW-1:0] tail_pnew,
    output logic [PW-1:0] tail_pold,
    output logic [TW-1:0] next_idx,
    output logic [TW-1:0] last_idx,
    output logic          full,
    output logic          empty
);
    logic [RW-1:0] ring [DEPTH];
    logic [TW-1:0] head, tail;
    logic [CW-1:0] count;
    logic [RW-1:0] head_rec, tail_rec;

    function automatic logic [TW-1:0] inc_ptr(input logic [TW-1:0] p);
        return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [TW-1:0] dec_ptr(input logic [TW-1:0] p);
        return (p == '0) ? TW'(DEPTH - 1) : p - 1'b1;
    endfunction

    // Ring storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ring[k] <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                ring[tail] <= {push_has, push_ldst, push_pnew, push_pold};
                tail       <= inc_ptr(tail);
            end else if (pop_tail) begin
                tail <= dec_ptr(tail);
            end
            if (pop_head) head <= inc_ptr(head);
            count <= count + CW'(push) - CW'(pop_head) - CW'(pop_tail);
        end
    end

    // Oldest and youngest record fields, slot indices and flags.
    always_comb begin
        last_idx  = dec_ptr(tail);
        next_idx  = tail;
        head_rec  = ring[head];
        tail_rec  = ring[last_idx];
        head_has  = head_rec[RW-1];
        head_pold = head_rec[PW-1:0];
        tail_has  = tail_rec[RW-1];
        tail_ldst = tail_rec[RW-2 -: LW];
        tail_pnew = tail_rec[2*PW-1 -: PW];
        tail_pold = tail_rec[PW-1:0];
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
    end

    AST_AL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R5
    AST_AL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (pop_head || pop_tail) |-> !empty); // R6
    AST_AL_ONE_END: assert property (@(posedge clk) disable iff (!rst_n) pop_tail |-> !(push || pop_head)); // R9
endmodule

// File: rtl/rename_map_unit.sv
// Rename stage: maps sources, assigns fresh destinations, keeps an undo record,
// retires records on graduation and unwinds records on abort, one per cycle.
// Assumes abort_tag names a live slot and no graduation is requested while an
// abort or unwind is in progress.
module rename_map_unit
    import rmu_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 64,
    parameter int AL_DEPTH = 48,
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int TW = $clog2(AL_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_has_dst,
    input  logic [LW-1:0] dec_dst,
    input  logic [LW-1:0] dec_src_a,
    input  logic [LW-1:0] dec_src_b,
    input  logic          grad_valid,
    input  logic          abort_valid,
    input  logic [TW-1:0] abort_tag,
    output logic          stall,
    output logic [PW-1:0] phy_src_a,
    output logic [PW-1:0] phy_src_b,
    output logic [PW-1:0] phy_dst,
    output logic [PW-1:0] phy_dst_old,
    output logic [TW-1:0] ren_tag
);
    rn_mode_e      mode;
    logic [TW-1:0] target;
    logic          needs, ren_fire, grad_fire, walk_fire;
    logic          fl_pop, fl_push, fl_empty;
    logic [PW-1:0] fl_head, fl_push_val;
    logic          map_we;
    logic [LW-1:0] map_widx;
    logic [PW-1:0] map_wval;
    logic          head_has, tail_has, al_full, al_empty;
    logic [PW-1:0] head_pold, tail_pnew, tail_pold;
    logic [LW-1:0] tail_ldst;
    logic [TW-1:0] next_idx, last_idx;

    // Accept, retire and unwind decisions plus write-port steering.
    always_comb begin
        needs       = dec_has_dst && (dec_dst != '0);
        walk_fire   = (mode == RN_WALK);
        stall       = walk_fire || abort_valid || al_full || (needs && fl_empty);
        ren_fire    = dec_valid && !stall;
        grad_fire   = grad_valid && !al_empty && !walk_fire && !abort_valid;
        fl_pop      = ren_fire && needs;
        fl_push     = (grad_fire && head_has) || (walk_fire && tail_has);
        fl_push_val = walk_fire ? tail_pnew : head_pold;
        map_we      = fl_pop || (walk_fire && tail_has);
        map_widx    = walk_fire ? tail_ldst : dec_dst;
        map_wval    = walk_fire ? tail_pold : fl_head;
        phy_dst     = needs ? fl_head : '0;
        ren_tag     = next_idx;
    end

    // Mode register: enter unwind on abort, leave once the target slot is undone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= RN_RUN;
            target <= '0;
        end else if (mode == RN_RUN) begin
            if (abort_valid) begin
                mode   <= RN_WALK;
                target <= abort_tag;
            end
        end else if (last_idx == target) begin
            mode <= RN_RUN;
        end
    end

    rmu_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(dec_src_a), .rd_b_idx(dec_src_b), .rd_d_idx(dec_dst),
        .rd_a(phy_src_a), .rd_b(phy_src_b), .rd_d(phy_dst_old),
        .wr_en(map_we), .wr_idx(map_widx), .wr_val(map_wval)
    );

    rmu_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop(fl_pop), .push(fl_push), .push_val(fl_push_val),
        .head_val(fl_head), .empty(fl_empty)
    );

    rmu_active_list #(.DEPTH(AL_DEPTH), .LW(LW), .PW(PW)) u_active (
        .clk(clk), .rst_n(rst_n),
        .push(ren_fire), .push_has(needs), .push_ldst(dec_dst),
        .push_pnew(fl_head), .push_pold(phy_dst_old),
        .pop_head(grad_fire), .pop_tail(walk_fire),
        .head_has(head_has), .head_pold(head_pold),
        .tail_has(tail_has), .tail_ldst(tail_ldst),
        .tail_pnew(tail_pnew), .tail_pold(tail_pold),
        .next_idx(next_idx), .last_idx(last_idx),
        .full(al_full), .empty(al_empty)
    );

    AST_STALL_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n) abort_valid |=> stall); // R9
    AST_ABORT_LIVE: assert property (@(posedge clk) disable iff (!rst_n) abort_valid |-> !al_empty); // R9
    AST_GRAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (abort_valid || mode == RN_WALK) |-> !grad_valid); // R9
    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ren_fire |=> ren_tag == (($past(ren_tag) == TW'(AL_DEPTH - 1)) ? '0 : $past(ren_tag) + 1'b1)); // R5
endmodule

// File: tb/tb_rename_map_unit.sv
module tb_rename_map_unit;
    localparam int NL = 32;
    localparam int NP = 64;
    localparam int AL = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0, dec_has_dst = 1'b0;
    logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic       grad_valid = 1'b0, abort_valid = 1'b0;
    logic [5:0] abort_tag = '0;
    logic       stall;
    logic [5:0] phy_src_a, phy_src_b, phy_dst, phy_dst_old, ren_tag;

    always #5 clk = ~clk;

    rename_map_unit #(.NUM_LOG(NL), .NUM_PHYS(NP), .AL_DEPTH(AL)) dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_has_dst(dec_has_dst), .dec_dst(dec_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .grad_valid(grad_valid), .abort_valid(abort_valid), .abort_tag(abort_tag),
        .stall(stall), .phy_src_a(phy_src_a), .phy_src_b(phy_src_b),
        .phy_dst(phy_dst), .phy_dst_old(phy_dst_old), .ren_tag(ren_tag)
    );

    typedef struct {
        bit has;
        int ldst;
        int pnew;
        int pold;
        int tag;
    } rec_t;

    rec_t alq[$];
    int   flq[$];
    int   mm[NL];
    int   ttag = 0;
    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One decode cycle against the model.
    task automatic step(bit v, bit hd, int d, int sa, int sb, bit g, string req);
        bit   needs, es, acc, gok;
        int   pnew;
        rec_t o;
        @(negedge clk);
        dec_valid = v; dec_has_dst = hd; dec_dst = 5'(d);
        dec_src_a = 5'(sa); dec_src_b = 5'(sb);
        grad_valid = g; abort_valid = 1'b0;
        #2;
        needs = hd && (d != 0);
        es    = (alq.size() == AL) || (needs && flq.size() == 0);
        chk(req, "stall", int'(stall), int'(es));
        chk("R2", "src_a", int'(phy_src_a), mm[sa]);
        chk("R2", "src_b", int'(phy_src_b), mm[sb]);
        acc = v && !es;
        gok = g && (alq.size() > 0);
        if (acc) begin
            chk(req, "dst_old", int'(phy_dst_old), mm[d]);
            if (needs) chk(req, "dst", int'(phy_dst), flq[0]);
            chk("R5", "tag", int'(ren_tag), ttag);
        end
        @(posedge clk);
        if (gok) o = alq.pop_front();
        if (acc) begin
            pnew = needs ? flq.pop_front() : 0;
            alq.push_back('{needs, d, pnew, mm[d], ttag});
            if (needs) mm[d] = pnew;
            ttag = (ttag + 1) % AL;
        end
        if (gok && o.has) flq.push_back(o.pold);
    endtask

    // Read every mapping through the source ports.
    task automatic sweep(string req);
        for (int r = 0; r < NL; r += 2) begin
            @(negedge clk);
            dec_valid = 1'b0; dec_has_dst = 1'b0; grad_valid = 1'b0; abort_valid = 1'b0;
            dec_src_a = 5'(r); dec_src_b = 5'(r + 1);
            #2;
            chk(req, "map_a", int'(phy_src_a), mm[r]);
            chk(req, "map_b", int'(phy_src_b), mm[r + 1]);
        end
    endtask

    // Abort to a slot, then count stalled cycles of the unwind.
    task automatic do_abort(int tag);
        int   n, cnt;
        rec_t r;
        @(negedge clk);
        dec_valid = 1'b0; dec_has_dst = 1'b0; grad_valid = 1'b0;
        abort_valid = 1'b1; abort_tag = 6'(tag);
        #2;
        chk("R9", "stall_abort_cycle", int'(stall), 1);
        @(posedge clk);
        n = 0;
        do begin
            r = alq.pop_back();
            if (r.has) begin
                mm[r.ldst] = r.pold;
                flq.push_back(r.pnew);
            end
            ttag = r.tag;
            n++;
        end while (r.tag != tag);
        @(negedge clk);
        abort_valid = 1'b0;
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            #2;
            if (stall) cnt++;
            else break;
            @(negedge clk);
        end
        chk("R9", "unwind_cycles", cnt, n);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) mm[i] = i;
        for (int i = NL; i < NP; i++) flq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping, first hand-out
        sweep("R1");
        step(1, 1, 5, 5, 0, 0, "R1");

        // R3 / R4: mixed destinations, zero and absent destinations
        for (int i = 0; i < 14; i++) begin
            bit hd;
            int d;
            hd = (i % 7 != 6);
            d  = (i % 5 == 4) ? 0 : (3 * i + 1) % 32;
            step(1, hd, d, (7 * i) % 32, d, 0, (!hd || d == 0) ? "R4" : "R3");
        end

        // R7: drain the pool, then no-destination work still flows
        for (int i = 0; flq.size() > 0 && i < 100; i++)
            step(1, 1, (i % 31) + 1, i % 32, (i + 3) % 32, 0, "R3");
        step(1, 1, 9, 1, 2, 0, "R7");
        for (int i = 0; alq.size() < AL && i < 100; i++)
            step(1, 0, 0, i % 32, 31 - (i % 32), 0, "R7");
        // R5: full active list blocks even without a destination
        step(1, 0, 0, 3, 4, 0, "R5");

        // R8: rename and graduation together
        for (int i = 0; i < 10; i++)
            step(1, 1, (i % 30) + 2, i, i + 1, 1, "R8");

        // R9 / R10: partial and complete unwinds
        do_abort(alq[alq.size() - 5].tag);
        sweep("R10");
        for (int i = 0; i < 6; i++)
            step(1, 1, (5 * i + 2) % 32, i, (5 * i + 2) % 32, 0, "R10");
        do_abort(alq[0].tag);
        sweep("R10");

        // R6: graduation on empty list, FIFO reuse of freed registers
        step(0, 0, 0, 0, 0, 1, "R6");
        step(1, 1, 7, 7, 7, 0, "R6");
        for (int i = 0; i < 40; i++)
            step(1, 1, (i * 11) % 32, i % 32, (i * 11) % 32, (i % 3) != 0, "R6");
        for (int i = 0; alq.size() > 0 && i < 100; i++)
            step(0, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 0, 1, "R6");
        for (int i = 0; i < 5; i++)
            step(1, 1, i + 1, i, i + 1, 0, "R6");
        sweep("R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule